// File: doc/BRIEF.md
# Perceptron Branch Direction and Target Predictor

This block guesses, at fetch time, whether a branch will be taken and where it will go. It keeps a direct-mapped table of small perceptrons. Each entry has one signed 8-bit weight per global history bit, one bias weight and a stored target. The entry is selected by folding the fetch address with the global outcome history. The direction is the sign of the perceptron's signed dot product with that history. The target comes from a known offset when the front end supplies one, otherwise from the stored value. A conditional branch predicted not taken falls through to the next sequential instruction.

When a branch resolves, the front end presents its address, its real outcome and its real target. The block has to find the entry that made the guess, so it keeps the global history seen at predict time in a small side table. That table is indexed by low address bits. Using that saved history, the block recomputes the index and the dot product. It trains the weights only when the guess was wrong or weakly confident. It always refreshes the stored target and shifts the outcome into the global history.

Top module: `pbp_predictor`

## Requirements
- R1: After reset every history weight is 0, every bias weight is 1, every stored target is 0, the global history is 0 and every side-table slot holds 0. A first conditional predict with no offset therefore returns taken with target 0.
- R2: The table index is bits [B+1:2] of the address XORed with the low B bits of the history in use (zero-extended when the history is shorter than B), giving 2^B entries.
- R3: The sum y is the bias plus, for each weight i in 0..L-1, +w[i] if history bit L-1-i is 1 and -w[i] if it is 0. The most significant history bit is the oldest outcome. The direction is taken when y >= 0.
- R4: A predict with the unconditional kind (pr_uncond=1) always returns taken.
- R5: The target is addr+offset when pr_offset is nonzero, otherwise the stored target of the entry. A conditional predict whose direction is not taken returns addr+4 instead.
- R6: An update trains the entry only when the recomputed direction differs from the outcome, or when |y| is below floor(1.93*L+14). Otherwise the weights are left unchanged.
- R7: When training, history weight i steps +1 if history bit L-1-i equals the outcome and -1 otherwise. The bias steps +1 on taken and -1 on not taken. All weights saturate at +127 and -127.
- R8: Every update overwrites the entry's stored target with the resolved target.
- R9: Every update sets the global history to ((history << 1) | taken) truncated to L bits. Without an update the history holds.
- R10: An update uses the history saved by the last predict whose address bits [S+1:2] match its own. A slot never written supplies history 0.
- R11: A predict and an update in the same cycle are allowed. The predict sees the state from before that update, and the update reads the side-table slot before the predict writes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| pr_valid | input | 1 | Predict request; saves the current history in the side table |
| pr_addr | input | ADDR_W | Address of the branch being predicted |
| pr_uncond | input | 1 | 1 = unconditional branch, 0 = conditional |
| pr_offset | input | ADDR_W | Known target offset; 0 means unknown |
| pr_taken | output | 1 | Predicted direction (combinational) |
| pr_target | output | ADDR_W | Predicted target (combinational) |
| up_valid | input | 1 | Update request for a resolved branch |
| up_addr | input | ADDR_W | Address of the resolved branch |
| up_taken | input | 1 | Actual outcome |
| up_target | input | ADDR_W | Resolved target |

## Verification
A predict and an update can land in the same cycle, and that is where ordering faults hide. The predict must see the table and history as they were before the edge. The update must read the side-table slot before the predict overwrites it. The bench sets this up in a long pipelined phase. In that phase each cycle presents the predict of a new branch together with the update of the previous one, drawn from a small address set so entries and side slots collide. A directed case also predicts and updates the same address at once. A behavioural model that applies the update before the predict's side write is compared with both outputs on every predicting cycle.

// File: rtl/pbp_pkg.sv
package pbp_pkg;
  localparam int WT_W = 8;
  localparam logic [WT_W-1:0] WT_POS_LIM = 8'h7F;
  localparam logic [WT_W-1:0] WT_NEG_LIM = 8'h81;
  typedef enum logic {BR_COND = 1'b0, BR_UNCOND = 1'b1} br_kind_e;
endpackage

// File: rtl/pbp_table.sv
module pbp_table #(
  parameter int IDX_BITS = 4,
  parameter int HIST_LEN = 8,
  parameter int ADDR_W   = 32,
  localparam int N_ENT   = 1 << IDX_BITS,
  localparam int WV_W    = (HIST_LEN + 1) * pbp_pkg::WT_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [IDX_BITS-1:0] rd_a_idx,
  output logic [WV_W-1:0]     rd_a_wv,
  output logic [ADDR_W-1:0]   rd_a_tgt,
  input  logic [IDX_BITS-1:0] rd_b_idx,
  output logic [WV_W-1:0]     rd_b_wv,
  input  logic                wr_en,
  input  logic [IDX_BITS-1:0] wr_idx,
  input  logic [WV_W-1:0]     wr_wv,
  input  logic [ADDR_W-1:0]   wr_tgt
);
  localparam logic [WV_W-1:0] WV_INIT = WV_W'(1) << (HIST_LEN * pbp_pkg::WT_W);

  logic [WV_W-1:0]   wv_q  [N_ENT];
  logic [ADDR_W-1:0] tgt_q [N_ENT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < N_ENT; e++) begin
        wv_q[e]  <= WV_INIT;
        tgt_q[e] <= '0;
      end
    end else if (wr_en) begin
      wv_q[wr_idx]  <= wr_wv;
      tgt_q[wr_idx] <= wr_tgt;
    end
  end

  assign rd_a_wv  = wv_q[rd_a_idx];
  assign rd_a_tgt = tgt_q[rd_a_idx];
  assign rd_b_wv  = wv_q[rd_b_idx];
endmodule

// File: rtl/pbp_hist_side.sv
module pbp_hist_side #(
  parameter int SIDE_BITS = 5,
  parameter int HIST_LEN  = 8,
  localparam int N_SLOT   = 1 << SIDE_BITS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [SIDE_BITS-1:0] wr_slot,
  input  logic [HIST_LEN-1:0]  wr_hist,
  input  logic [SIDE_BITS-1:0] rd_slot,
  output logic [HIST_LEN-1:0]  rd_hist
);
  logic [HIST_LEN-1:0] slot_q [N_SLOT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < N_SLOT; s++) slot_q[s] <= '0;
    end else if (wr_en) begin
      slot_q[wr_slot] <= wr_hist;
    end
  end

  assign rd_hist = slot_q[rd_slot];
endmodule

// File: rtl/pbp_dot.sv
module pbp_dot #(
  parameter int HIST_LEN = 8,
  parameter int YW       = 13,
  localparam int WV_W    = (HIST_LEN + 1) * pbp_pkg::WT_W
) (
  input  logic [WV_W-1:0]     wv,
  input  logic [HIST_LEN-1:0] hist,
  output logic [YW-1:0]       y
);
  localparam int W = pbp_pkg::WT_W;

  function automatic logic [YW-1:0] widen(input logic [W-1:0] w);
    return {{(YW-W){w[W-1]}}, w};
  endfunction

  always_comb begin
    y = widen(wv[HIST_LEN*W +: W]);
    for (int i = 0; i < HIST_LEN; i++) begin
      if (hist[HIST_LEN-1-i]) y = y + widen(wv[i*W +: W]);
      else                    y = y - widen(wv[i*W +: W]);
    end
  end
endmodule

// File: rtl/pbp_train.sv
module pbp_train #(
  parameter int HIST_LEN = 8,
  parameter int YW       = 13,
  parameter int THRESH   = 29,
  localparam int WV_W    = (HIST_LEN + 1) * pbp_pkg::WT_W
) (
  input  logic [WV_W-1:0]     old_wv,
  input  logic [HIST_LEN-1:0] hist,
  input  logic [YW-1:0]       y,
  input  logic                taken,
  output logic                mispred,
  output logic                conf_low,
  output logic                fire,
  output logic [WV_W-1:0]     new_wv
);
  import pbp_pkg::*;
  localparam int W = WT_W;

  function automatic logic [W-1:0] sat_step(input logic [W-1:0] w, input logic up);
    if (up) return (w == WT_POS_LIM) ? w : w + W'(1);
    return (w == WT_NEG_LIM) ? w : w - W'(1);
  endfunction

  logic [YW-1:0] y_mag;

  always_comb begin
    y_mag    = y[YW-1] ? (~y + YW'(1)) : y;
    mispred  = (~y[YW-1]) != taken;
    conf_low = y_mag < YW'(THRESH);
    fire     = mispred | conf_low;
    new_wv   = old_wv;
    if (fire) begin
      for (int i = 0; i < HIST_LEN; i++)
        new_wv[i*W +: W] = sat_step(old_wv[i*W +: W], hist[HIST_LEN-1-i] == taken);
      new_wv[HIST_LEN*W +: W] = sat_step(old_wv[HIST_LEN*W +: W], taken);
    end
  end
endmodule

// File: rtl/pbp_predictor.sv
module pbp_predictor #(
  parameter int ADDR_W    = 32,
  parameter int IDX_BITS  = 4,
  parameter int HIST_LEN  = 8,
  parameter int SIDE_BITS = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pr_valid,
  input  logic [ADDR_W-1:0] pr_addr,
  input  logic              pr_uncond,
  input  logic [ADDR_W-1:0] pr_offset,
  output logic              pr_taken,
  output logic [ADDR_W-1:0] pr_target,
  input  logic              up_valid,
  input  logic [ADDR_W-1:0] up_addr,
  input  logic              up_taken,
  input  logic [ADDR_W-1:0] up_target
);
  import pbp_pkg::*;
  localparam int WV_W   = (HIST_LEN + 1) * WT_W;
  localparam int YW     = $clog2((HIST_LEN + 1) * 128) + 2;
  localparam int THRESH = (193 * HIST_LEN + 1400) / 100;

  function automatic logic [IDX_BITS-1:0] fold_idx(input logic [ADDR_W-1:0] a,
                                                   input logic [HIST_LEN-1:0] h);
    logic [IDX_BITS+HIST_LEN-1:0] hx;
    hx = {{IDX_BITS{1'b0}}, h};
    return a[IDX_BITS+1:2] ^ hx[IDX_BITS-1:0];
  endfunction

  logic [HIST_LEN-1:0] ghist_q;
  logic [HIST_LEN-1:0] up_hist;
  logic [IDX_BITS-1:0] pr_idx, up_idx;
  logic [WV_W-1:0]     pr_wv, up_wv, new_wv;
  logic [ADDR_W-1:0]   pr_stored_tgt, pr_base_tgt;
  logic [YW-1:0]       pr_y, up_y;
  logic                pr_dir, train_fire, mispred, conf_low, tbl_wr_en;
  br_kind_e            pr_kind;
  logic                unused_addr_bits;

  assign unused_addr_bits = ^up_addr;
  assign pr_kind   = br_kind_e'(pr_uncond);
  assign pr_idx    = fold_idx(pr_addr, ghist_q);
  assign up_idx    = fold_idx(up_addr, up_hist);
  assign tbl_wr_en = up_valid;

  pbp_hist_side #(.SIDE_BITS(SIDE_BITS), .HIST_LEN(HIST_LEN)) side_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en(pr_valid), .wr_slot(pr_addr[SIDE_BITS+1:2]), .wr_hist(ghist_q),
    .rd_slot(up_addr[SIDE_BITS+1:2]), .rd_hist(up_hist)
  );

  pbp_table #(.IDX_BITS(IDX_BITS), .HIST_LEN(HIST_LEN), .ADDR_W(ADDR_W)) tbl_i (
    .clk(clk), .rst_n(rst_n),
    .rd_a_idx(pr_idx), .rd_a_wv(pr_wv), .rd_a_tgt(pr_stored_tgt),
    .rd_b_idx(up_idx), .rd_b_wv(up_wv),
    .wr_en(tbl_wr_en), .wr_idx(up_idx), .wr_wv(new_wv), .wr_tgt(up_target)
  );

  pbp_dot #(.HIST_LEN(HIST_LEN), .YW(YW)) dot_pr_i (.wv(pr_wv), .hist(ghist_q), .y(pr_y));
  pbp_dot #(.HIST_LEN(HIST_LEN), .YW(YW)) dot_up_i (.wv(up_wv), .hist(up_hist), .y(up_y));

  pbp_train #(.HIST_LEN(HIST_LEN), .YW(YW), .THRESH(THRESH)) train_i (
    .old_wv(up_wv), .hist(up_hist), .y(up_y), .taken(up_taken),
    .mispred(mispred), .conf_low(conf_low), .fire(train_fire), .new_wv(new_wv)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ghist_q <= '0;
    else if (up_valid) ghist_q <= HIST_LEN'({ghist_q, up_taken});
  end

  assign pr_dir = ~pr_y[YW-1];

  always_comb begin
    pr_base_tgt = (pr_offset != '0) ? pr_addr + pr_offset : pr_stored_tgt;
    pr_taken    = (pr_kind == BR_UNCOND) | pr_dir;
    pr_target   = pr_taken ? pr_base_tgt : pr_addr + ADDR_W'(4);
  end
endmodule

// File: rtl/pbp_checker.sv
module pbp_checker #(
  parameter int ADDR_W   = 32,
  parameter int HIST_LEN = 8,
  parameter int WV_W     = 72
) (
  input logic                clk,
  input logic                rst_n,
  input logic                pr_valid,
  input logic                pr_uncond,
  input logic                pr_taken,
  input logic [ADDR_W-1:0]   pr_addr,
  input logic [ADDR_W-1:0]   pr_target,
  input logic                up_valid,
  input logic                up_taken,
  input logic [HIST_LEN-1:0] ghist_q,
  input logic                train_fire,
  input logic                tbl_wr_en,
  input logic [WV_W-1:0]     up_wv,
  input logic [WV_W-1:0]     new_wv
);
  AST_UNCOND_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    pr_valid && pr_uncond |-> pr_taken); // R4
  AST_FALLTHRU_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    pr_valid && !pr_taken |-> pr_target == pr_addr + ADDR_W'(4)); // R5
  AST_HIST_SHIFT_IN: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid |=> ghist_q[0] == $past(up_taken)); // R9
  AST_HIST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !up_valid |=> $stable(ghist_q)); // R9
  AST_QUIET_KEEPS_WEIGHTS: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid && !train_fire |-> new_wv == up_wv); // R6
  for (genvar i = 0; i <= HIST_LEN; i++) begin : g_wt
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      tbl_wr_en |-> new_wv[i*8 +: 8] != 8'h80); // R7
  end
endmodule

bind pbp_predictor pbp_checker #(.ADDR_W(ADDR_W), .HIST_LEN(HIST_LEN), .WV_W(WV_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .pr_valid(pr_valid), .pr_uncond(pr_uncond),
  .pr_taken(pr_taken), .pr_addr(pr_addr), .pr_target(pr_target),
  .up_valid(up_valid), .up_taken(up_taken), .ghist_q(ghist_q),
  .train_fire(train_fire), .tbl_wr_en(tbl_wr_en), .up_wv(up_wv), .new_wv(new_wv)
);

// File: tb/pbp_predictor_tb_top.sv
`timescale 1ns/1ps
module pbp_predictor_tb_top;
  localparam int AW = 32, B = 4, L = 8, S = 5;
  localparam int NE = 1 << B, NS = 1 << S;
  localparam int THR = (193 * L + 1400) / 100;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pr_valid = 0, pr_uncond = 0, up_valid = 0, up_taken = 0;
  logic [AW-1:0] pr_addr = '0, pr_offset = '0, up_addr = '0, up_target = '0;
  logic pr_taken;
  logic [AW-1:0] pr_target;

  int checks = 0, failures = 0;
  bit done = 0;
  string phase = "R1";

  int mw [NE][L+1];
  logic [AW-1:0] mt [NE];
  int mhist;
  int mside [NS];

  always #2 clk = ~clk;

  pbp_predictor #(.ADDR_W(AW), .IDX_BITS(B), .HIST_LEN(L), .SIDE_BITS(S)) dut_i (
    .clk(clk), .rst_n(rst_n), .pr_valid(pr_valid), .pr_addr(pr_addr),
    .pr_uncond(pr_uncond), .pr_offset(pr_offset), .pr_taken(pr_taken),
    .pr_target(pr_target), .up_valid(up_valid), .up_addr(up_addr),
    .up_taken(up_taken), .up_target(up_target)
  );

  function automatic int eidx(logic [AW-1:0] a, int h);
    return int'(((a >> 2) ^ AW'(h)) % NE);
  endfunction

  function automatic int sidx(logic [AW-1:0] a);
    return int'((a >> 2) % NS);
  endfunction

  function automatic int ysum(int e, int h);
    int s = mw[e][L];
    for (int i = 0; i < L; i++)
      if (((h >> (L - 1 - i)) & 1) == 1) s += mw[e][i]; else s -= mw[e][i];
    return s;
  endfunction

  task automatic check(string what, logic [AW-1:0] act, logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s act=%0h exp=%0h", phase, what, act, exp);
    end
  endtask

  task automatic model_update(logic [AW-1:0] ua, bit ut, logic [AW-1:0] utg);
    int h = mside[sidx(ua)];
    int e = eidx(ua, h);
    int y = ysum(e, h);
    int mag = (y < 0) ? -y : y;
    if (((y >= 0) != ut) || mag < THR) begin
      for (int i = 0; i < L; i++) begin
        if ((((h >> (L - 1 - i)) & 1) == 1) == ut) begin
          if (mw[e][i] < 127) mw[e][i]++;
        end else if (mw[e][i] > -127) mw[e][i]--;
      end
      if (ut) begin if (mw[e][L] < 127) mw[e][L]++; end
      else if (mw[e][L] > -127) mw[e][L]--;
    end
    mt[e] = utg;
    mhist = ((mhist << 1) | int'(ut)) & ((1 << L) - 1);
  endtask

  task automatic cyc(bit pv, logic [AW-1:0] pa, bit pu, logic [AW-1:0] po,
                     bit uv, logic [AW-1:0] ua, bit ut, logic [AW-1:0] utg);
    int hpre;
    @(negedge clk);
    pr_valid = pv; pr_addr = pa; pr_uncond = pu; pr_offset = po;
    up_valid = uv; up_addr = ua; up_taken = ut; up_target = utg;
    #1;
    if (pv) begin
      int e = eidx(pa, mhist);
      bit dir = ysum(e, mhist) >= 0;
      bit tk = pu || dir;
      logic [AW-1:0] tg = (po != 0) ? pa + po : mt[e];
      if (!tk) tg = pa + 4;
      check("taken", AW'(pr_taken), AW'(tk));
      check("target", pr_target, tg);
    end
    @(posedge clk);
    hpre = mhist;
    if (uv) model_update(ua, ut, utg);
    if (pv) mside[sidx(pa)] = hpre;
  endtask

  task automatic br(logic [AW-1:0] a, bit u, logic [AW-1:0] o, bit t, logic [AW-1:0] tg);
    cyc(1, a, u, o, 0, '0, 0, '0);
    cyc(0, '0, 0, '0, 1, a, t, tg);
  endtask

  initial begin
    for (int e = 0; e < NE; e++) begin
      for (int i = 0; i < L; i++) mw[e][i] = 0;
      mw[e][L] = 1;
      mt[e] = '0;
    end
    for (int s = 0; s < NS; s++) mside[s] = 0;
    mhist = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    phase = "R1 reset";
    @(negedge clk);
    pr_valid = 1; pr_addr = 32'h0000_0100; pr_uncond = 0; pr_offset = '0; #1;
    check("taken", AW'(pr_taken), 32'd1);   // R1
    check("target", pr_target, 32'd0);     // R1
    cyc(1, 32'h0000_0234, 0, '0, 0, '0, 0, '0);

    phase = "R2 R3 R6 R7 R8 R10 loop";
    for (int n = 0; n < 60; n++) begin
      br(32'h0000_1040, 0, '0, (n % 4) != 3, 32'h0000_0F00);
      br(32'h0000_2238, 0, '0, 0, 32'h0000_3000);
    end

    phase = "R4 R5 kinds";
    for (int n = 0; n < 20; n++) begin
      br(32'h0000_4400 + AW'(n * 8), 1, '0, 1, 32'h0000_5000 + AW'(n));
      br(32'h0000_4404, 0, 32'h0000_0040, n % 2 == 0, 32'h0000_4444);
      br(32'h0000_6600, 0, '0, 0, 32'h0000_7000);
    end

    phase = "R11 same address";
    cyc(1, 32'h0000_1040, 0, '0, 0, '0, 0, '0);
    cyc(1, 32'h0000_1040, 0, '0, 1, 32'h0000_1040, 0, 32'h0000_0ABC);
    cyc(1, 32'h0000_1040, 0, '0, 1, 32'h0000_1040, 1, 32'h0000_0DEF);
    cyc(0, '0, 0, '0, 1, 32'h0000_1040, 1, 32'h0000_0DEF);

    phase = "R9 R10 R11 pipelined";
    begin
      logic [AW-1:0] pool [6] = '{32'h1000, 32'h1010, 32'h2004, 32'h2084, 32'h30C8, 32'h1090};
      bit pvld = 0; logic [AW-1:0] pa = '0;
      for (int n = 0; n < 3000; n++) begin
        int k = int'($urandom % 6);
        bit u = ($urandom % 10) == 0;
        logic [AW-1:0] o = (($urandom % 7) == 0) ? 32'h0000_0020 : '0;
        bit t = (k < 3) ? (($urandom % 8) != 0) : (($urandom % 3) == 0);
        cyc(1, pool[k], u, o, pvld, pa, t, pa + 32'h0000_0100);
        pvld = 1; pa = pool[k];
      end
      cyc(0, '0, 0, '0, 1, pa, 1, pa + 32'h0000_0100);
    end
    cyc(1, 32'h0000_1000, 0, '0, 0, '0, 0, '0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule